// File: doc/BRIEF.md
# Conditional Sum Adder

This block adds two unsigned N-bit operands and a carry-in and produces an N-bit sum and a carry-out. It has no clock and no state. No carry travels from bit to bit. Every bit position works out its result twice, once for an incoming carry of 0 and once for an incoming carry of 1. A tree of 2:1 selector stages then combines neighbouring groups, and each stage doubles the group width.

At each merge, the lower group's carry under a given assumption picks which of the upper group's two candidates survives under that same assumption. After log2(N) merges a single group spans the whole word and still holds two candidates. The external carry-in picks one of them.

N must be a power of two and at least 2. Any other value stops elaboration.

Top module: `cond_sum_adder`

## Requirements
- R1: For every operand pair and carry-in, the concatenation {cout, sum} equals the unsigned value a + b + cin, taken as N+1 bits.
- R2: Sum bit 0 equals a[0] xor b[0] when cin is 0, and equals not(a[0] xor b[0]) when cin is 1. The carry into bit 1 is a[0] and b[0] when cin is 0, and a[0] or b[0] when cin is 1.
- R3: In every group of the tree, the candidate formed under an incoming carry of 1 equals the candidate formed under 0, plus one. The group's carry under 0 implies its carry under 1.
- R4: When every bit position propagates (a xor b is all ones), cout equals cin and every sum bit equals not cin.
- R5: The outputs follow the inputs with no clock edge between a change of input and the new result.
- R6: With both operands zero, sum equals cin zero-extended to N bits and cout is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand, unsigned |
| b | input | N | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0; selects the final candidate |
| sum | output | N | Low N bits of a + b + cin |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
The hardest case to reach is a carry that must cross every merge boundary. The lower candidate of each group has to select the upper one at every level of the tree, all the way to the top. This only happens when every bit propagates, and random operands almost never produce that pattern at 32 bits.

The bench drives complementary operand pairs and all-ones against zero under both carry-in values, so the selects flip at every level. It also walks a single generate bit up the word so that each group boundary is crossed in turn. The 4-bit and 8-bit instances are swept over every input combination.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // True when n is a power of two and at least 2.
  function automatic bit width_ok(input int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/csa_cond_cell.sv
// One bit position: both candidate (sum, carry) pairs, independent of the
// carry that will eventually arrive.
module csa_cond_cell (
  input  logic a,
  input  logic b,
  output logic s0,
  output logic c0,
  output logic s1,
  output logic c1
);
  logic half;

  assign half = a ^ b;
  assign s0   = half;
  assign c0   = a & b;
  assign s1   = ~half;
  assign c1   = a | b;
endmodule

// File: rtl/csa_pair_mux.sv
// W input pairs sharing one select line; each pair yields one output bit.
module csa_pair_mux #(
  parameter int W = 2
) (
  input  logic         sel,
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  output logic [W-1:0] out
);
  for (genvar i = 0; i < W; i++) begin : g_pair
    assign out[i] = sel ? in1[i] : in0[i];
  end
endmodule

// File: rtl/csa_section.sv
// A W-bit group that yields two candidates: one for an assumed incoming
// carry of 0 and one for 1. It is built recursively from two W/2 groups.
module csa_section #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s0,
  output logic         c0,
  output logic [W-1:0] s1,
  output logic         c1
);
  if (W == 1) begin : g_leaf
    csa_cond_cell cell_i (
      .a(a[0]), .b(b[0]),
      .s0(s0[0]), .c0(c0), .s1(s1[0]), .c1(c1)
    );
  end else begin : g_merge
    localparam int H = W / 2;

    logic [H-1:0] lo_s0, lo_s1, hi_s0, hi_s1;
    logic         lo_c0, lo_c1, hi_c0, hi_c1;

    csa_section #(.W(H)) lo_i (
      .a(a[H-1:0]), .b(b[H-1:0]),
      .s0(lo_s0), .c0(lo_c0), .s1(lo_s1), .c1(lo_c1)
    );
    csa_section #(.W(H)) hi_i (
      .a(a[W-1:H]), .b(b[W-1:H]),
      .s0(hi_s0), .c0(hi_c0), .s1(hi_s1), .c1(hi_c1)
    );

    // The lower group's carry under each assumption picks the upper candidate.
    csa_pair_mux #(.W(H + 1)) pick0_i (
      .sel(lo_c0),
      .in0({hi_c0, hi_s0}),
      .in1({hi_c1, hi_s1}),
      .out({c0, s0[W-1:H]})
    );
    csa_pair_mux #(.W(H + 1)) pick1_i (
      .sel(lo_c1),
      .in0({hi_c0, hi_s0}),
      .in1({hi_c1, hi_s1}),
      .out({c1, s1[W-1:H]})
    );

    assign s0[H-1:0] = lo_s0;
    assign s1[H-1:0] = lo_s1;
  end

  always_comb begin
    // R3
    cand_step_chk: assert ({c1, s1} == ({c0, s0} + 1'b1));
    // R3
    carry_order_chk: assert (!c0 || c1);
  end
endmodule

// File: rtl/cond_sum_adder.sv
module cond_sum_adder #(
  parameter int N = 32
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  import csa_pkg::*;

  localparam int LEVELS = $clog2(N);

  if (!width_ok(N) || ((1 << LEVELS) != N)) begin : g_bad_width
    $error("cond_sum_adder: N must be a power of two, at least 2");
  end

  logic [N-1:0] full_s0, full_s1;
  logic         full_c0, full_c1;

  csa_section #(.W(N)) root_i (
    .a(a), .b(b),
    .s0(full_s0), .c0(full_c0), .s1(full_s1), .c1(full_c1)
  );

  // The true carry-in resolves the two whole-word candidates.
  csa_pair_mux #(.W(N + 1)) final_i (
    .sel(cin),
    .in0({full_c0, full_s0}),
    .in1({full_c1, full_s1}),
    .out({cout, sum})
  );

  always_comb begin
    // R1
    sum_exact_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin}));
    // R4
    ripple_span_chk: assert (!(&(a ^ b)) || ((cout == cin) && (sum == {N{~cin}})));
  end
endmodule

// File: tb/cond_sum_adder_tb_top.sv
module cond_sum_adder_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_vec  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  logic [3:0]  a4, b4, s4;
  logic [7:0]  a8, b8, s8;
  logic [31:0] a, b, sum;
  logic        ci4, co4, ci8, co8, cin, cout;

  cond_sum_adder #(.N(4))  dut4_i (.a(a4), .b(b4), .cin(ci4), .sum(s4), .cout(co4));
  cond_sum_adder #(.N(8))  dut8_i (.a(a8), .b(b8), .cin(ci8), .sum(s8), .cout(co8));
  cond_sum_adder #(.N(32)) dut_i  (.a(a),  .b(b),  .cin(cin), .sum(sum), .cout(cout));

  task automatic tally(input bit ok, input string req, input logic [32:0] act,
                       input logic [32:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check32(input logic [31:0] x, input logic [31:0] y, input logic c,
                         input string req);
    logic [32:0] exp;
    @(posedge clk); #1;
    a = x; b = y; cin = c;
    @(negedge clk);
    exp = {1'b0, x} + {1'b0, y} + {32'd0, c};
    tally({cout, sum} == exp, req, {cout, sum}, exp);
  endtask

  // R1 R2: every input combination at 4 bits
  task automatic run_exhaustive4();
    for (int i = 0; i < 512; i++) begin
      logic [4:0] exp;
      @(posedge clk); #1;
      {ci4, a4, b4} = i[8:0];
      @(negedge clk);
      exp = {1'b0, a4} + {1'b0, b4} + {4'd0, ci4};
      tally({co4, s4} == exp, "R1 n4", {28'd0, co4, s4}, {28'd0, exp});
      tally(s4[0] == (ci4 ? ~(a4[0] ^ b4[0]) : (a4[0] ^ b4[0])), "R2 bit0",
            {32'd0, s4[0]}, {32'd0, ci4 ^ a4[0] ^ b4[0]});
    end
  endtask

  // R1: every input combination at 8 bits
  task automatic run_exhaustive8();
    for (int i = 0; i < 131072; i++) begin
      logic [8:0] exp;
      @(posedge clk); #1;
      {ci8, a8, b8} = i[16:0];
      @(negedge clk);
      exp = {1'b0, a8} + {1'b0, b8} + {8'd0, ci8};
      tally({co8, s8} == exp, "R1 n8", {24'd0, co8, s8}, {24'd0, exp});
    end
  endtask

  // R2: the carry into bit 1 follows and/or of bit 0 depending on cin
  task automatic run_cell_carry();
    for (int i = 0; i < 8; i++) begin
      logic ea, eb, ec, exp_c1;
      {ec, ea, eb} = i[2:0];
      exp_c1 = ec ? (ea | eb) : (ea & eb);
      check32({31'd0, ea}, {31'd0, eb}, ec, "R2 cell");
      // bit 1 of the sum is the carry into it, since bit 1 of both operands is 0
      tally(sum[1] == exp_c1, "R2 carry", {32'd0, sum[1]}, {32'd0, exp_c1});
    end
  endtask

  // R4: full propagate patterns flip every merge select
  task automatic run_propagate();
    logic [31:0] pat;
    for (int c = 0; c < 2; c++) begin
      check32(32'hFFFF_FFFF, 32'd0, c[0], "R4 ones");
      tally((cout == c[0]) && (sum == {32{~c[0]}}), "R4 span",
            {cout, sum}, {c[0], {32{~c[0]}}});
      check32(32'hA5A5_5A5A, 32'h5A5A_A5A5, c[0], "R4 mixed");
    end
    for (int k = 0; k < 32; k++) begin
      pat = 32'hFFFF_FFFF << k;
      check32(pat, 32'd1 << k, 1'b0, "R4 walk");
      check32(~pat, pat, 1'b1, "R4 walk");
    end
  endtask

  // R5: the result changes with no clock edge in between
  task automatic run_comb();
    @(posedge clk); #1;
    a = 32'h0000_00FF; b = 32'h0000_0001; cin = 1'b0;
    #2;
    tally({cout, sum} == 33'h100, "R5 first", {cout, sum}, 33'h100);
    a = 32'hFFFF_FFFF; b = 32'h0000_0001;
    #1;
    tally({cout, sum} == 33'h1_0000_0000, "R5 second", {cout, sum}, 33'h1_0000_0000);
  endtask

  // R6: zero operands, the carry-in alone sets the result
  task automatic run_zero();
    check32(32'd0, 32'd0, 1'b0, "R6 zero");
    tally({cout, sum} == 33'd0, "R6 cin0", {cout, sum}, 33'd0);
    check32(32'd0, 32'd0, 1'b1, "R6 one");
    tally({cout, sum} == 33'd1, "R6 cin1", {cout, sum}, 33'd1);
  endtask

  // R1: random 32-bit vectors
  task automatic run_random();
    for (int i = 0; i < 3000; i++)
      check32($urandom, $urandom, 1'($urandom), "R1 rand");
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    a4 = '0; b4 = '0; ci4 = 1'b0;
    a8 = '0; b8 = '0; ci8 = 1'b0;
    run_zero();
    run_comb();
    run_cell_carry();
    run_propagate();
    run_exhaustive4();
    run_exhaustive8();
    run_random();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule